// File: doc/BRIEF.md
# Control Endpoint IN Data Buffer

This block holds the bytes a USB device returns to the host in the data stage of a control read. The CPU loads them one byte per write into a 64-entry store through a port that is write-only; reading that port always yields zero. Software then marks the packet complete with a data-end command and arms transmission with a transmit-enable command. A serial interface engine (SIE) sits on the bus side. It reports IN tokens, the host's handshake outcome, SETUP tokens and the move to the status stage. It takes the packet as a valid/ready byte stream that marks the final byte, or as a single zero-length beat.

An IN token that finds transmission armed and a packet released starts the stream from the first stored byte. Otherwise the block pulses a NAK indication. A correct ACK empties the store and drops the enable, the data-end flag and the data-present flag together. A missing or corrupted handshake keeps the packet, and the next IN token sends it again from its first byte. A SETUP token, or a move to the status stage, flushes everything at once, and this flush takes priority over any CPU command in the same cycle.

Stream rules: a beat transfers on a rising edge where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the beat on offer stays unchanged. The sink may hold `tx_ready` low for any number of cycles. A flush withdraws the stream in the following cycle.

Top module: `usb_ep0_in_buf`

## Requirements
- R1: The store accepts up to 64 bytes, one per cycle in which `cpu_wr_en` is high, and `level` reports how many are held; bytes leave in the order written.
- R2: `cpu_rd_data` reads 0x00 at all times, whether the store is empty or holds data.
- R3: An IN token arriving while `txen` is 0 or no packet is released produces a one-cycle `in_nak` pulse in the next cycle and no stream beat.
- R4: A `sie_ack` while the block awaits a handshake clears `txen`, `present` and `level` to 0 in the next cycle.
- R5: Data-end with N>0 bytes held sets `present` to 1, and an armed IN token then streams exactly those N bytes, with `tx_last`=1 only on the N-th and `tx_zlp`=0.
- R6: Data-end with the store empty sets `present` to 1, and an armed IN token then yields exactly one beat with `tx_zlp`=1 and `tx_last`=1.
- R7: `sie_setup` clears `level`, `present`, `txen` and the stream in the next cycle, whatever state the block is in.
- R8: `sie_status` clears `level`, `present`, `txen` and the stream in the next cycle when the data-stage packet was not acknowledged.
- R9: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data`, `tx_last` and `tx_zlp` hold their values.
- R10: A `sie_noack` while awaiting a handshake leaves `txen`, `present` and `level` unchanged, and the next IN token resends the whole packet from its first byte.
- R11: A write while 64 bytes are held is dropped and sets the sticky `ovf` flag, which only `sw_clr_ovf` clears.
- R12: After data-end, CPU writes are dropped without changing `level` or setting `ovf` until the packet is acknowledged or flushed.
- R13: A flush in the same cycle as a CPU write or a transmit-enable command wins: `level` and `txen` read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU byte to store |
| cpu_rd_data | output | 8 | CPU read value of the byte port, always 0x00 |
| sw_set_txen | input | 1 | Software arms transmission |
| sw_set_dend | input | 1 | Software marks the packet complete (data-end) |
| sw_clr_ovf | input | 1 | Software clears the overflow flag |
| txen | output | 1 | Transmit-enable flag |
| present | output | 1 | Data-present flag (packet released) |
| ovf | output | 1 | Sticky overflow flag |
| level | output | 7 | Number of bytes held |
| sie_in_tok | input | 1 | IN token received for this endpoint |
| sie_ack | input | 1 | Host acknowledged the packet |
| sie_noack | input | 1 | Handshake missing or corrupted |
| sie_setup | input | 1 | SETUP token received |
| sie_status | input | 1 | Control transfer entered the status stage |
| in_nak | output | 1 | IN token answered with NAK |
| tx_valid | output | 1 | Stream beat offered |
| tx_ready | input | 1 | SIE accepts the beat |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_zlp | output | 1 | Beat stands for a zero-length packet |

## Verification
The checker watches these rules on every cycle: the fill level stays within bounds, a stalled beat holds still, and a stream beat appears only while transmission is armed and a packet is released. It also checks that a zero-length beat is always marked last, that a flush or an ACK clears the flags in the next cycle, that a missed handshake keeps the packet, and that the overflow flag stays set. Only the bench scenarios can show the rest. That covers byte order and length across whole packets, the resend after a lost handshake, NAK answers, the read-as-zero port, writes dropped after data-end, and flush priority over same-cycle commands.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/ep0_byte_store.sv
module ep0_byte_store
  import usb_ep0_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [BYTE_W-1:0]                wr_data,
  input  logic                             clear,
  input  logic [$clog2(DEPTH)-1:0]         rd_addr,
  output logic [BYTE_W-1:0]                rd_data,
  output logic [$clog2(DEPTH+1)-1:0]       fill,
  output logic                             full
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] slot_val [DEPTH];
  logic              push;

  assign full = (cnt_q == CW'(DEPTH));
  assign push = wr_en && !full && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else if (push)  cnt_q <= cnt_q + 1'b1;
  end

  // one register per slot; the write position is the current fill count
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (push && (cnt_q == CW'(g))) q <= wr_data;
    end
    assign slot_val[g] = q;
  end

  assign rd_data = slot_val[rd_addr];
  assign fill    = cnt_q;

  logic unused_aw;
  assign unused_aw = ^AW;
endmodule

// File: rtl/ep0_flag_ctrl.sv
module ep0_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_txen,
  input  logic set_dend,
  input  logic clr_ovf,
  input  logic flush,
  input  logic ack_done,
  input  logic wr_attempt,
  input  logic full,
  output logic wr_accept,
  output logic txen,
  output logic released,
  output logic ovf
);
  logic txen_q, rel_q, ovf_q;
  logic drop_full;

  // writes are locked once the packet is released; flush beats everything
  assign wr_accept = wr_attempt && !rel_q && !full && !flush;
  assign drop_full = wr_attempt && !rel_q &&  full && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n)                  txen_q <= 1'b0;
    else if (flush || ack_done)  txen_q <= 1'b0;
    else if (set_txen)           txen_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  rel_q <= 1'b0;
    else if (flush || ack_done)  rel_q <= 1'b0;
    else if (set_dend)           rel_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ovf_q <= 1'b0;
    else if (clr_ovf)   ovf_q <= 1'b0;
    else if (drop_full) ovf_q <= 1'b1;
  end

  assign txen     = txen_q;
  assign released = rel_q;
  assign ovf      = ovf_q;
endmodule

// File: rtl/ep0_tx_seq.sv
module ep0_tx_seq
  import usb_ep0_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_tok,
  input  logic                       ack,
  input  logic                       noack,
  input  logic                       flush,
  input  logic                       txen,
  input  logic                       released,
  input  logic [$clog2(DEPTH+1)-1:0] fill,
  input  logic [BYTE_W-1:0]          byte_in,
  input  logic                       out_ready,
  output logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic                       out_valid,
  output logic [BYTE_W-1:0]          out_data,
  output logic                       out_last,
  output logic                       out_zlp,
  output logic                       nak,
  output logic                       waiting,
  output logic                       ack_done
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  tx_state_e     st_q, st_d;
  logic [AW-1:0] rp_q, rp_d;
  logic          nak_q;
  logic          start, answer_nak, zlp, last, beat;

  assign start      = in_tok && (st_q == TX_IDLE) && txen && released && !flush;
  assign answer_nak = in_tok && (st_q == TX_IDLE) && !(txen && released) && !flush;
  assign zlp        = (fill == '0);
  assign last       = zlp || ((CW'(rp_q) + 1'b1) == fill);
  assign beat       = (st_q == TX_SEND) && out_ready;
  assign ack_done   = (st_q == TX_WAIT) && ack && !flush;

  always_comb begin
    st_d = st_q;
    rp_d = rp_q;
    if (flush) begin
      st_d = TX_IDLE;
      rp_d = '0;
    end else begin
      unique case (st_q)
        TX_IDLE: if (start) begin
          st_d = TX_SEND;
          rp_d = '0;      // every send, first or repeated, begins at the packet start
        end
        TX_SEND: if (beat) begin
          if (last) st_d = TX_WAIT;
          else      rp_d = rp_q + 1'b1;
        end
        TX_WAIT: if (ack || noack) begin
          st_d = TX_IDLE;
          rp_d = '0;
        end
        default: st_d = TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      rp_q  <= '0;
      nak_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rp_q  <= rp_d;
      nak_q <= answer_nak;
    end
  end

  assign rd_addr   = rp_q;
  assign out_valid = (st_q == TX_SEND);
  assign out_data  = (st_q == TX_SEND && !zlp) ? byte_in : '0;
  assign out_last  = (st_q == TX_SEND) && last;
  assign out_zlp   = (st_q == TX_SEND) && zlp;
  assign nak       = nak_q;
  assign waiting   = (st_q == TX_WAIT);
endmodule

// File: rtl/usb_ep0_in_buf.sv
module usb_ep0_in_buf
  import usb_ep0_pkg::*;
#(
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_wr_en,
  input  logic [7:0]                 cpu_wr_data,
  output logic [7:0]                 cpu_rd_data,
  input  logic                       sw_set_txen,
  input  logic                       sw_set_dend,
  input  logic                       sw_clr_ovf,
  output logic                       txen,
  output logic                       present,
  output logic                       ovf,
  output logic [$clog2(DEPTH+1)-1:0] level,
  input  logic                       sie_in_tok,
  input  logic                       sie_ack,
  input  logic                       sie_noack,
  input  logic                       sie_setup,
  input  logic                       sie_status,
  output logic                       in_nak,
  output logic                       tx_valid,
  input  logic                       tx_ready,
  output logic [7:0]                 tx_data,
  output logic                       tx_last,
  output logic                       tx_zlp
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic              flush, ack_done, wr_accept, full, released, hs_wait;
  logic [AW-1:0]     rd_addr;
  logic [BYTE_W-1:0] rd_byte;
  logic [CW-1:0]     fill;

  assign flush       = sie_setup || sie_status;
  assign cpu_rd_data = '0;

  ep0_flag_ctrl u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_txen   (sw_set_txen),
    .set_dend   (sw_set_dend),
    .clr_ovf    (sw_clr_ovf),
    .flush      (flush),
    .ack_done   (ack_done),
    .wr_attempt (cpu_wr_en),
    .full       (full),
    .wr_accept  (wr_accept),
    .txen       (txen),
    .released   (released),
    .ovf        (ovf)
  );

  ep0_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_accept),
    .wr_data (cpu_wr_data),
    .clear   (flush || ack_done),
    .rd_addr (rd_addr),
    .rd_data (rd_byte),
    .fill    (fill),
    .full    (full)
  );

  ep0_tx_seq #(.DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tok    (sie_in_tok),
    .ack       (sie_ack),
    .noack     (sie_noack),
    .flush     (flush),
    .txen      (txen),
    .released  (released),
    .fill      (fill),
    .byte_in   (rd_byte),
    .out_ready (tx_ready),
    .rd_addr   (rd_addr),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .out_last  (tx_last),
    .out_zlp   (tx_zlp),
    .nak       (in_nak),
    .waiting   (hs_wait),
    .ack_done  (ack_done)
  );

  assign present = released;
  assign level   = fill;
endmodule

// File: rtl/usb_ep0_in_buf_checker.sv
module usb_ep0_in_buf_checker #(
  parameter int unsigned DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       sie_setup,
  input logic                       sie_status,
  input logic                       sie_ack,
  input logic                       sie_noack,
  input logic                       hs_wait,
  input logic                       tx_valid,
  input logic                       tx_ready,
  input logic [7:0]                 tx_data,
  input logic                       tx_last,
  input logic                       tx_zlp,
  input logic                       txen,
  input logic                       present,
  input logic                       ovf,
  input logic                       sw_clr_ovf,
  input logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r3_stream_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (txen && present));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_wait && sie_ack) |=> (!txen && !present && level == '0));

  a_r6_zlp_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_zlp) |-> tx_last);

  a_r7_setup_flush: assert property (@(posedge clk) disable iff (!rst_n)
    sie_setup |=> (!txen && !present && !tx_valid && level == '0));

  a_r8_status_flush: assert property (@(posedge clk) disable iff (!rst_n)
    sie_status |=> (!txen && !present && !tx_valid && level == '0));

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !sie_setup && !sie_status) |=>
      (tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_zlp)));

  a_r10_noack_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_wait && sie_noack && !sie_ack && !sie_setup && !sie_status) |=>
      (txen && present && $stable(level)));

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !sw_clr_ovf) |=> ovf);
endmodule

bind usb_ep0_in_buf usb_ep0_in_buf_checker #(.DEPTH(DEPTH)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sie_setup  (sie_setup),
  .sie_status (sie_status),
  .sie_ack    (sie_ack),
  .sie_noack  (sie_noack),
  .hs_wait    (hs_wait),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .tx_data    (tx_data),
  .tx_last    (tx_last),
  .tx_zlp     (tx_zlp),
  .txen       (txen),
  .present    (present),
  .ovf        (ovf),
  .sw_clr_ovf (sw_clr_ovf),
  .level      (level)
);

// File: tb/usb_ep0_in_buf_bench.sv
module usb_ep0_in_buf_bench;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr_en = 0, sw_set_txen = 0, sw_set_dend = 0, sw_clr_ovf = 0;
  logic [7:0] cpu_wr_data = '0;
  logic sie_in_tok = 0, sie_ack = 0, sie_noack = 0, sie_setup = 0, sie_status = 0;
  logic tx_ready = 0;
  logic [7:0] cpu_rd_data, tx_data;
  logic txen, present, ovf, in_nak, tx_valid, tx_last, tx_zlp;
  logic [6:0] level;

  int n_chk = 0;
  int n_fail = 0;
  logic [9:0] exp_q [$];   // {zlp, last, data}

  always #5 clk = ~clk;

  usb_ep0_in_buf #(.DEPTH(DEPTH)) u_usb_ep0_in_buf (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .sw_set_txen(sw_set_txen), .sw_set_dend(sw_set_dend),
    .sw_clr_ovf(sw_clr_ovf), .txen(txen), .present(present), .ovf(ovf), .level(level),
    .sie_in_tok(sie_in_tok), .sie_ack(sie_ack), .sie_noack(sie_noack),
    .sie_setup(sie_setup), .sie_status(sie_status), .in_nak(in_nak),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_zlp(tx_zlp)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // inputs change 2 time units after a rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [7:0] b);
    cpu_wr_en = 1; cpu_wr_data = b; step(); cpu_wr_en = 0;
  endtask

  task automatic load(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) wr(8'(i) ^ seed);
  endtask

  task automatic expect_pkt(input int n, input logic [7:0] seed);
    if (n == 0) exp_q.push_back({1'b1, 1'b1, 8'h00});
    else for (int i = 0; i < n; i++)
      exp_q.push_back({1'b0, (i == n - 1), 8'(i) ^ seed});
  endtask

  task automatic pulse_dend(); sw_set_dend = 1; step(); sw_set_dend = 0; endtask
  task automatic pulse_txen(); sw_set_txen = 1; step(); sw_set_txen = 0; endtask
  task automatic pulse_in();   sie_in_tok = 1;  step(); sie_in_tok = 0;  endtask
  task automatic pulse_ack();  sie_ack = 1;     step(); sie_ack = 0;     endtask

  task automatic drain(input bit choppy, input string tag);
    int k = 0;
    while (exp_q.size() != 0 && k < 500) begin
      tx_ready = choppy ? (k % 3 != 1) : 1'b1;
      step();
      k++;
    end
    tx_ready = 0;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic chk_clear(input string tag);
    chk(level == 0 && !present && !txen && !tx_valid, tag,
        {level, present, txen, tx_valid}, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5/R6 unexpected beat", {tx_zlp, tx_last, tx_data}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk({tx_zlp, tx_last, tx_data} == e, "R1/R5/R6/R10 stream beat",
            {tx_zlp, tx_last, tx_data}, e);
      end
    end
  end

  initial begin
    #1500000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] held;
    repeat (3) step();
    rst_n = 1;
    step();

    // reset state
    chk(!txen && !present && !ovf && level == 0 && !tx_valid && !in_nak,
        "reset", {txen, present, ovf, level}, 0);
    chk(cpu_rd_data == 8'h00, "R2 empty read", cpu_rd_data, 0);

    // R3: IN with nothing armed
    pulse_in();
    chk(in_nak == 1 && !tx_valid, "R3 nak unarmed", in_nak, 1);
    step();
    chk(in_nak == 0, "R3 nak one cycle", in_nak, 0);

    // R5 short packet with back-pressure
    load(5, 8'h30);
    chk(level == 5, "R1 level", level, 5);
    chk(cpu_rd_data == 8'h00, "R2 read with data", cpu_rd_data, 0);
    pulse_dend();
    chk(present == 1, "R5 present", present, 1);
    pulse_in();
    chk(in_nak == 1 && !tx_valid, "R3 nak when txen 0", in_nak, 1);
    pulse_txen();
    expect_pkt(5, 8'h30);
    pulse_in();
    chk(in_nak == 0 && tx_valid, "R5 send starts", tx_valid, 1);
    held = tx_data;
    step(); step();
    chk(tx_valid && tx_data == held && tx_data == 8'h30, "R9 stall hold", tx_data, 8'h30);
    drain(1'b1, "R5 beats delivered");
    chk(txen && present, "R4 awaiting handshake", {txen, present}, 3);
    pulse_ack();
    chk_clear("R4 ack clears");

    // R6 zero-length packet
    pulse_dend();
    chk(present && level == 0, "R6 present empty", {present, level}, 8'h80);
    pulse_txen();
    expect_pkt(0, 8'h00);
    pulse_in();
    drain(1'b0, "R6 zlp delivered");
    pulse_ack();
    chk_clear("R6 ack clears");

    // R10 retransmit after lost handshake
    load(3, 8'h5A);
    pulse_dend(); pulse_txen();
    expect_pkt(3, 8'h5A);
    pulse_in();
    drain(1'b0, "R10 first send");
    sie_noack = 1; step(); sie_noack = 0;
    chk(txen && present && level == 3, "R10 kept after noack", level, 3);
    expect_pkt(3, 8'h5A);
    pulse_in();
    drain(1'b1, "R10 resend whole");
    pulse_ack();
    chk_clear("R4 ack after resend");

    // R11 overflow and full packet
    load(DEPTH, 8'hA5);
    chk(level == 7'(DEPTH) && !ovf, "R1 full level", level, DEPTH);
    wr(8'hEE);
    chk(ovf && level == 7'(DEPTH), "R11 ovf set", {ovf, level}, {1'b1, 7'(DEPTH)});
    step();
    chk(ovf == 1, "R11 ovf sticky", ovf, 1);
    sw_clr_ovf = 1; step(); sw_clr_ovf = 0;
    chk(ovf == 0, "R11 ovf cleared", ovf, 0);
    pulse_dend(); pulse_txen();
    expect_pkt(DEPTH, 8'hA5);
    pulse_in();
    drain(1'b1, "R1 64-byte order");
    pulse_ack();
    chk_clear("R4 ack full");

    // R12 writes locked after data-end
    load(2, 8'hC0);
    pulse_dend();
    wr(8'h77);
    chk(level == 2 && !ovf, "R12 write dropped", level, 2);
    pulse_txen();
    expect_pkt(2, 8'hC0);
    pulse_in();
    drain(1'b0, "R12 only two bytes");
    pulse_ack();

    // R7 SETUP flush mid-send
    load(4, 8'h11);
    pulse_dend(); pulse_txen();
    pulse_in();
    chk(tx_valid == 1, "R7 send in progress", tx_valid, 1);
    sie_setup = 1; step(); sie_setup = 0;
    chk_clear("R7 setup flush");

    // R8 status stage flush before ACK
    load(2, 8'h44);
    pulse_dend(); pulse_txen();
    expect_pkt(2, 8'h44);
    pulse_in();
    drain(1'b0, "R8 sent");
    sie_status = 1; step(); sie_status = 0;
    chk_clear("R8 status flush");
    pulse_in();
    chk(in_nak == 1 && !tx_valid, "R8 nak after flush", in_nak, 1);

    // R13 flush wins over same-cycle commands
    load(1, 8'h01);
    cpu_wr_en = 1; cpu_wr_data = 8'h99; sw_set_txen = 1; sie_setup = 1;
    step();
    cpu_wr_en = 0; sw_set_txen = 0; sie_setup = 0;
    chk(level == 0 && !txen, "R13 flush priority", {level, txen}, 0);

    step();
    finish_run();
  end
endmodule